// File: doc/BRIEF.md
# Status Channel Receiver with Calendar Mapping

This block terminates the 2-bit out-of-band status channel of a packet interface. A word is captured on each cycle of the status clock, on the rising or the falling edge as a configuration input selects. The block finds the calendar frame boundaries and checks the parity word that closes each frame. It declares sync after a run of clean frames and drops it after a run of parity failures. Each slot is tagged with a port number, either the slot index itself or an entry of a table that can be programmed. The result reaches the faster system clock as a stream of valid/port/status triples.

A frame is `CAL_LEN*CAL_REP` slot words, then the framing code 2'b11, then the 2-bit parity word. Slot words carry one of 2'b00, 2'b01 or 2'b10. While `hold_i` is high the control machine stays disabled. The calendar table is loaded through the write port while the block is held, and is then treated as static. The system clock must run faster than the status clock. The crossing FIFO is read every system cycle, and `valid_o` falls as soon as the FIFO is empty.

Top module: `stat_rx`

## Requirements
- R1: During and right after reset, `valid_o` and `sync_o` are low.
- R2: A frame is `CAL_LEN*CAL_REP` slot words, then 2'b11, then the parity word. A 2'b11 in a slot position, or any other code in the framing position, is a framing error. It drops sync at once and restarts the search for a 2'b11. After such a 2'b11, the word that follows is skipped and slot counting begins.
- R3: The parity word must equal the bitwise XOR of all slot words of the frame. Bit 1 is the XOR of the slot bit-1 values and bit 0 is the XOR of the slot bit-0 values. A frame with a wrong parity word does not count towards sync.
- R4: Sync is declared after `GOOD_N` (default 2) consecutive frames with correct parity, counted from frame alignment.
- R5: Sync is lost after `BAD_N` (default 2) consecutive parity failures. A single failure between good frames keeps sync.
- R6: Only slots of frames that begin while in sync are forwarded. Nothing is forwarded while out of sync.
- R7: With `asym_en_i` low, slot k of the frame maps to port k mod `CAL_LEN`, where the first slot after the parity word is slot 0.
- R8: With `asym_en_i` high, the port is entry (k mod `CAL_LEN`) of the calendar table. `cal_we_i` writes `cal_data_i` to entry `cal_addr_i` on a system clock edge.
- R9: `fall_edge_i` high samples `stat_i` on the falling edge of `stat_clk_i`. Low samples it on the rising edge.
- R10: While `hold_i` is high the block stays disabled: no sync and no forwarded status.
- R11: Each forwarded slot gives exactly one `valid_o` cycle, in arrival order, carrying its port on `port_o` and its code on `status_o`. `valid_o` is low whenever the FIFO is empty.
- R12: `sync_o` follows the internal sync state through two system clock flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| stat_clk_i | input | 1 | Status channel clock |
| sys_clk_i | input | 1 | System clock, faster than the status clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| stat_i | input | 2 | Status channel word |
| fall_edge_i | input | 1 | 1: sample on falling edge, 0: on rising edge |
| hold_i | input | 1 | Frame-release control; high keeps the machine disabled |
| asym_en_i | input | 1 | 1: slot-to-port via calendar table |
| cal_we_i | input | 1 | Calendar table write strobe (system clock) |
| cal_addr_i | input | SLOT_W | Calendar table entry index |
| cal_data_i | input | PORT_W | Port number stored in the entry |
| valid_o | output | 1 | Port/status valid |
| port_o | output | PORT_W | Port of the forwarded slot |
| status_o | output | 2 | Status code of the forwarded slot |
| sync_o | output | 1 | Frame sync indicator |

## Verification
A slot word is registered by the sampler on the status edge after it is driven. The framer writes it into the FIFO on the next status rising edge. The write pointer then needs two system edges to cross, and `valid_o` rises on the following system edge. The total is about one status period plus three to four system cycles. The internal sync flag changes on the edge that consumes a parity word, and `sync_o` follows two system edges later. The bench therefore samples `sync_o` halfway through the next frame, four status periods after the deciding word, which is well past that latency. Forwarded triples are collected at system falling edges and compared in order against an independently built list. The comparison runs only after several idle framing codes, which can never be forwarded, so every due entry has arrived.

// File: rtl/stat_rx_pkg.sv
`timescale 1ns/1ps
package stat_rx_pkg;
  localparam int unsigned STAT_W = 2;
  localparam logic [STAT_W-1:0] FRAME_CODE = 2'b11;

  typedef enum logic [2:0] {
    FS_OFF,
    FS_HUNT,
    FS_SKIP,
    FS_SLOT,
    FS_FWORD,
    FS_DIP
  } frm_state_e;
endpackage

// File: rtl/stat_rx_sync.sv
`timescale 1ns/1ps
module stat_rx_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/stat_rx_sampler.sv
`timescale 1ns/1ps
module stat_rx_sampler import stat_rx_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [STAT_W-1:0] word_o
);
  logic [STAT_W-1:0] neg_q, word_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= '0;
    else         neg_q <= stat_i;
  end

  // falling-edge capture is retimed so the framer sees one rising-edge stream
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= fall_i ? neg_q : stat_i;
  end

  assign word_o = word_q;
endmodule

// File: rtl/stat_rx_framer.sv
`timescale 1ns/1ps
module stat_rx_framer import stat_rx_pkg::*; #(
  parameter int CAL_LEN = 4,
  parameter int CAL_REP = 2,
  parameter int GOOD_N  = 2,
  parameter int BAD_N   = 2,
  parameter int SLOT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic [STAT_W-1:0] word_i,
  output logic              push_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [STAT_W-1:0] status_o,
  output logic              sync_o
);
  localparam int FRAME_W = CAL_LEN * CAL_REP;
  localparam int CNT_W   = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam int G_W     = (GOOD_N > 1) ? $clog2(GOOD_N) : 1;
  localparam int B_W     = (BAD_N > 1) ? $clog2(BAD_N) : 1;

  frm_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic [STAT_W-1:0] dip_q;
  logic [G_W-1:0]    good_q;
  logic [B_W-1:0]    bad_q;
  logic              sync_q;
  logic              is_code;

  assign is_code = (word_i == FRAME_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_OFF;
      cnt_q   <= '0;
      slot_q  <= '0;
      dip_q   <= '0;
      good_q  <= '0;
      bad_q   <= '0;
      sync_q  <= 1'b0;
    end else if (hold_i) begin
      state_q <= FS_OFF;
      sync_q  <= 1'b0;
      good_q  <= '0;
      bad_q   <= '0;
    end else begin
      unique case (state_q)
        FS_OFF:  state_q <= FS_HUNT;
        FS_HUNT: if (is_code) state_q <= FS_SKIP;
        FS_SKIP: begin
          state_q <= FS_SLOT;
          cnt_q   <= '0;
          slot_q  <= '0;
          dip_q   <= '0;
        end
        FS_SLOT: begin
          if (is_code) begin
            state_q <= FS_HUNT;
            sync_q  <= 1'b0;
            good_q  <= '0;
            bad_q   <= '0;
          end else begin
            dip_q  <= dip_q ^ word_i;
            slot_q <= (slot_q == SLOT_W'(CAL_LEN - 1)) ? '0 : slot_q + 1'b1;
            if (cnt_q == CNT_W'(FRAME_W - 1)) state_q <= FS_FWORD;
            else                              cnt_q   <= cnt_q + 1'b1;
          end
        end
        FS_FWORD: begin
          if (is_code) begin
            state_q <= FS_DIP;
          end else begin
            state_q <= FS_HUNT;
            sync_q  <= 1'b0;
            good_q  <= '0;
            bad_q   <= '0;
          end
        end
        FS_DIP: begin
          state_q <= FS_SLOT;
          cnt_q   <= '0;
          slot_q  <= '0;
          dip_q   <= '0;
          if (word_i == dip_q) begin
            bad_q <= '0;
            if (!sync_q) begin
              if (good_q == G_W'(GOOD_N - 1)) begin
                sync_q <= 1'b1;
                good_q <= '0;
              end else begin
                good_q <= good_q + 1'b1;
              end
            end
          end else begin
            good_q <= '0;
            if (sync_q) begin
              if (bad_q == B_W'(BAD_N - 1)) begin
                sync_q <= 1'b0;
                bad_q  <= '0;
              end else begin
                bad_q <= bad_q + 1'b1;
              end
            end
          end
        end
        default: state_q <= FS_OFF;
      endcase
    end
  end

  assign push_o   = (state_q == FS_SLOT) && sync_q && !is_code && !hold_i;
  assign slot_o   = slot_q;
  assign status_o = word_i;
  assign sync_o   = sync_q;
endmodule

// File: rtl/stat_rx_calendar.sv
`timescale 1ns/1ps
module stat_rx_calendar #(
  parameter int CAL_LEN = 4,
  parameter int SLOT_W  = 2,
  parameter int PORT_W  = 8
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] waddr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              asym_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [PORT_W-1:0] port_o
);
  logic [PORT_W-1:0] tbl_q [CAL_LEN];

  // written in the system domain only while held; read quasi-statically
  for (genvar g = 0; g < CAL_LEN; g++) begin : g_ent
    always_ff @(posedge wclk_i or negedge rst_ni) begin
      if (!rst_ni)                               tbl_q[g] <= '0;
      else if (we_i && waddr_i == SLOT_W'(g))    tbl_q[g] <= wdata_i;
    end
  end

  assign port_o = asym_i ? tbl_q[slot_i] : PORT_W'(slot_i);
endmodule

// File: rtl/stat_rx_cdc_fifo.sv
`timescale 1ns/1ps
module stat_rx_cdc_fifo #(
  parameter int DW = 10,
  parameter int AW = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wbin_q, wgray_q, rbin_q, rgray_q;
  logic [AW:0]   rgray_w, wgray_r, wbin_n, rbin_n;
  logic          wr;

  stat_rx_sync #(.W(AW + 1)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_w)
  );
  stat_rx_sync #(.W(AW + 1)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_r)
  );

  assign full_o  = (wgray_q == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
  assign empty_o = (rgray_q == wgray_r);
  assign wr      = push_i && !full_o;
  assign wbin_n  = wbin_q + 1'b1;
  assign rbin_n  = rbin_q + 1'b1;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr) begin
      wbin_q  <= wbin_n;
      wgray_q <= wbin_n ^ (wbin_n >> 1);
    end
  end

  always_ff @(posedge wclk_i) begin
    if (wr) mem_q[wbin_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (!empty_o) begin
      rbin_q  <= rbin_n;
      rgray_q <= rbin_n ^ (rbin_n >> 1);
      valid_o <= 1'b1;
      data_o  <= mem_q[rbin_q[AW-1:0]];
    end else begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/stat_rx.sv
`timescale 1ns/1ps
module stat_rx import stat_rx_pkg::*; #(
  parameter int CAL_LEN = 4,
  parameter int CAL_REP = 2,
  parameter int GOOD_N  = 2,
  parameter int BAD_N   = 2,
  parameter int PORT_W  = 8,
  parameter int FIFO_AW = 2,
  parameter int SLOT_W  = (CAL_LEN > 1) ? $clog2(CAL_LEN) : 1
) (
  input  logic              stat_clk_i,
  input  logic              sys_clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        stat_i,
  input  logic              fall_edge_i,
  input  logic              hold_i,
  input  logic              asym_en_i,
  input  logic              cal_we_i,
  input  logic [SLOT_W-1:0] cal_addr_i,
  input  logic [PORT_W-1:0] cal_data_i,
  output logic              valid_o,
  output logic [PORT_W-1:0] port_o,
  output logic [1:0]        status_o,
  output logic              sync_o
);
  localparam int DW = PORT_W + STAT_W;

  logic [STAT_W-1:0] samp_word, frm_status;
  logic [SLOT_W-1:0] frm_slot;
  logic [PORT_W-1:0] cal_port;
  logic [DW-1:0]     fifo_dout;
  logic              frm_push, frm_sync, fifo_full, fifo_empty;

  stat_rx_sampler u_samp (
    .clk_i(stat_clk_i), .rst_ni(rst_ni), .fall_i(fall_edge_i),
    .stat_i(stat_i), .word_o(samp_word)
  );

  stat_rx_framer #(
    .CAL_LEN(CAL_LEN), .CAL_REP(CAL_REP), .GOOD_N(GOOD_N),
    .BAD_N(BAD_N), .SLOT_W(SLOT_W)
  ) u_frm (
    .clk_i(stat_clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .word_i(samp_word),
    .push_o(frm_push), .slot_o(frm_slot), .status_o(frm_status), .sync_o(frm_sync)
  );

  stat_rx_calendar #(.CAL_LEN(CAL_LEN), .SLOT_W(SLOT_W), .PORT_W(PORT_W)) u_cal (
    .wclk_i(sys_clk_i), .rst_ni(rst_ni), .we_i(cal_we_i), .waddr_i(cal_addr_i),
    .wdata_i(cal_data_i), .asym_i(asym_en_i), .slot_i(frm_slot), .port_o(cal_port)
  );

  stat_rx_cdc_fifo #(.DW(DW), .AW(FIFO_AW)) u_fifo (
    .wclk_i(stat_clk_i), .rclk_i(sys_clk_i), .rst_ni(rst_ni),
    .push_i(frm_push), .data_i({cal_port, frm_status}),
    .full_o(fifo_full), .empty_o(fifo_empty),
    .valid_o(valid_o), .data_o(fifo_dout)
  );

  stat_rx_sync #(.W(1)) u_sync (
    .clk_i(sys_clk_i), .rst_ni(rst_ni), .d_i(frm_sync), .q_o(sync_o)
  );

  assign port_o   = fifo_dout[DW-1:STAT_W];
  assign status_o = fifo_dout[STAT_W-1:0];
endmodule

// File: rtl/stat_rx_chk.sv
`timescale 1ns/1ps
module stat_rx_chk #(
  parameter int CAL_LEN = 4,
  parameter int PORT_W  = 8
) (
  input logic              stat_clk_i,
  input logic              sys_clk_i,
  input logic              rst_ni,
  input logic              hold_i,
  input logic              asym_en_i,
  input logic              push,
  input logic              full,
  input logic              sync_int,
  input logic              valid_o,
  input logic [PORT_W-1:0] port_o,
  input logic              sync_o
);
  // R11
  no_overflow_chk: assert property (@(posedge stat_clk_i) disable iff (!rst_ni)
    push |-> !full);

  // R10
  hold_quiet_chk: assert property (@(posedge stat_clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i)) |-> !push && !sync_int);

  // R7
  port_range_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (valid_o && !asym_en_i) |-> (port_o < PORT_W'(CAL_LEN)));

  // R12
  sync_rise_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(sync_int));

  // R1
  reset_quiet_chk: assert property (@(posedge sys_clk_i)
    !rst_ni |=> !valid_o);
endmodule

bind stat_rx stat_rx_chk #(.CAL_LEN(CAL_LEN), .PORT_W(PORT_W)) chk_i (
  .stat_clk_i(stat_clk_i), .sys_clk_i(sys_clk_i), .rst_ni(rst_ni),
  .hold_i(hold_i), .asym_en_i(asym_en_i), .push(frm_push), .full(fifo_full),
  .sync_int(frm_sync), .valid_o(valid_o), .port_o(port_o), .sync_o(sync_o)
);

// File: tb/stat_rx_tb_top.sv
`timescale 1ns/1ps
module stat_rx_tb_top;
  localparam int CAL_LEN = 4;
  localparam int CAL_REP = 2;
  localparam int FW      = CAL_LEN * CAL_REP;
  localparam int PORT_W  = 8;

  logic       stat_clk = 1'b0, sys_clk = 1'b0, rst_n = 1'b0;
  logic [1:0] stat = 2'b11;
  logic       fall_tb = 1'b0, hold = 1'b0, asym_tb = 1'b0;
  logic       cal_we = 1'b0;
  logic [1:0] cal_addr = '0;
  logic [7:0] cal_data = '0;
  logic       valid;
  logic [7:0] port;
  logic [1:0] status;
  logic       sync;

  int n_chk = 0, n_fail = 0;
  logic [9:0] got_q[$];
  logic [9:0] exp_q[$];
  logic [7:0] tbl [CAL_LEN];

  always #2  sys_clk  = ~sys_clk;   // 250 MHz
  always #10 stat_clk = ~stat_clk;

  stat_rx #(.CAL_LEN(CAL_LEN), .CAL_REP(CAL_REP), .GOOD_N(2), .BAD_N(2)) dut_i (
    .stat_clk_i(stat_clk), .sys_clk_i(sys_clk), .rst_ni(rst_n), .stat_i(stat),
    .fall_edge_i(fall_tb), .hold_i(hold), .asym_en_i(asym_tb), .cal_we_i(cal_we),
    .cal_addr_i(cal_addr), .cal_data_i(cal_data), .valid_o(valid), .port_o(port),
    .status_o(status), .sync_o(sync)
  );

  always @(negedge sys_clk) if (rst_n && valid) got_q.push_back({port, status});

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // word valid only around the selected edge; junk around the other
  task automatic put_word(input logic [1:0] w);
    if (fall_tb) begin
      @(posedge stat_clk); #2 stat = w;
      @(negedge stat_clk); #2 stat = 2'b01;
    end else begin
      @(negedge stat_clk); #2 stat = w;
      @(posedge stat_clk); #2 stat = 2'b01;
    end
  endtask

  task automatic do_reset(input bit f, input bit h, input bit a);
    rst_n = 1'b0; stat = 2'b11; fall_tb = f; hold = h; asym_tb = a;
    repeat (3) @(posedge stat_clk);
    #1 rst_n = 1'b1;
    got_q.delete(); exp_q.delete();
  endtask

  task automatic align();
    for (int i = 0; i < FW + 2; i++) put_word(2'b00);
    put_word(2'b11);
    put_word(2'b10);
  endtask

  task automatic send_frame(input int seed, input bit emit, input bit bad_dip,
                            input bit bad_fw, input int sync_exp, input string tag);
    logic [1:0] acc = 2'b00;
    for (int i = 0; i < FW; i++) begin
      logic [1:0] w = 2'((seed * 7 + i * 5) % 3);
      int slot = i % CAL_LEN;
      acc ^= w;
      put_word(w);
      if (emit) exp_q.push_back({(asym_tb ? tbl[slot] : 8'(slot)), w});
      if (i == FW / 2 - 1 && sync_exp >= 0)
        chk(sync == sync_exp[0], {tag, " sync_o"}, int'(sync), sync_exp);
    end
    put_word(bad_fw ? 2'b01 : 2'b11);
    put_word(bad_dip ? ~acc : acc);
  endtask

  task automatic finish_cmp(input string tag);
    int bad = -1;
    for (int i = 0; i < 6; i++) put_word(2'b11);
    repeat (20) @(posedge sys_clk);
    @(negedge sys_clk);
    chk(got_q.size() == exp_q.size(), {tag, " R11 valid count"}, got_q.size(), exp_q.size());
    foreach (exp_q[i]) if (bad < 0 && (i >= got_q.size() || got_q[i] != exp_q[i])) bad = i;
    chk(bad < 0, {tag, " R11 port/status order"},
        (bad >= 0 && bad < got_q.size()) ? int'(got_q[bad]) : -1,
        (bad >= 0) ? int'(exp_q[bad]) : 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge sys_clk);
    @(negedge sys_clk);
    chk(!valid, "R1 valid_o in reset", int'(valid), 0);
    chk(!sync, "R1 sync_o in reset", int'(sync), 0);
    do_reset(0, 0, 0);
    repeat (3) @(posedge sys_clk);
    @(negedge sys_clk);
    chk(!valid && !sync, "R1 after release", int'({valid, sync}), 0);
  endtask

  task automatic t_direct();
    do_reset(0, 0, 0);
    align();
    send_frame(1, 0, 0, 0, 0, "R4 frame1");
    send_frame(2, 0, 0, 0, 0, "R4 frame2");
    send_frame(3, 1, 0, 0, 1, "R4 R12 synced");
    send_frame(4, 1, 0, 0, 1, "R7 direct");
    finish_cmp("R7 direct map");
  endtask

  task automatic t_dip();
    do_reset(0, 0, 0);
    align();
    send_frame(1, 0, 1, 0, 0, "R3 bad parity");
    send_frame(2, 0, 0, 0, 0, "R3 first good");
    send_frame(3, 0, 0, 0, 0, "R3 second good");
    send_frame(4, 1, 1, 0, 1, "R3 synced after parity");
    send_frame(5, 1, 0, 0, 1, "R5 single error kept");
    send_frame(6, 1, 1, 0, 1, "R5 error one");
    send_frame(7, 1, 1, 0, 1, "R5 error two");
    send_frame(8, 0, 0, 0, 0, "R5 sync lost");
    send_frame(9, 0, 0, 0, 0, "R6 out of sync");
    send_frame(10, 1, 0, 0, 1, "R4 reacquired");
    finish_cmp("R6 R5 forwarding");
  endtask

  task automatic t_ferr();
    do_reset(0, 0, 0);
    align();
    send_frame(1, 0, 0, 0, 0, "R2 acq1");
    send_frame(2, 0, 0, 0, 0, "R2 acq2");
    send_frame(3, 1, 0, 1, 1, "R2 bad framing word");
    send_frame(4, 0, 0, 0, 0, "R2 lost at framing error");
    send_frame(5, 0, 0, 0, 0, "R2 realign good1");
    send_frame(6, 0, 0, 0, 0, "R2 realign good2");
    send_frame(7, 1, 0, 0, 1, "R2 resynced");
    finish_cmp("R2 framing");
  endtask

  task automatic t_asym();
    do_reset(0, 1, 1);
    tbl[0] = 8'h05; tbl[1] = 8'h9C; tbl[2] = 8'h21; tbl[3] = 8'hF0;
    for (int i = 0; i < CAL_LEN; i++) begin
      @(negedge sys_clk);
      cal_we = 1'b1; cal_addr = 2'(i); cal_data = tbl[i];
    end
    @(negedge sys_clk);
    cal_we = 1'b0;
    hold = 1'b0;
    align();
    send_frame(11, 0, 0, 0, 0, "R8 acq1");
    send_frame(12, 0, 0, 0, 0, "R8 acq2");
    send_frame(13, 1, 0, 0, 1, "R8 table ports");
    send_frame(14, 1, 0, 0, 1, "R8 table ports");
    finish_cmp("R8 calendar map");
  endtask

  task automatic t_fall();
    do_reset(1, 0, 0);
    align();
    send_frame(21, 0, 0, 0, 0, "R9 acq1");
    send_frame(22, 0, 0, 0, 0, "R9 acq2");
    send_frame(23, 1, 0, 0, 1, "R9 falling edge sync");
    finish_cmp("R9 falling edge");
  endtask

  task automatic t_hold();
    do_reset(0, 1, 0);
    align();
    send_frame(31, 0, 0, 0, 0, "R10 held f1");
    send_frame(32, 0, 0, 0, 0, "R10 held f2");
    send_frame(33, 0, 0, 0, 0, "R10 held f3");
    send_frame(34, 0, 0, 0, 0, "R10 held f4");
    finish_cmp("R10 hold");
  endtask

  initial begin
    t_reset();
    t_direct();
    t_dip();
    t_ferr();
    t_asym();
    t_fall();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule